// File: doc/BRIEF.md
# In-Place G.711 Buffer Compander

This block sits on the data word of a serial channel's primary buffer and converts it between linear samples and 8-bit G.711 codes without any serial transfer. A build-time parameter fixes its direction. In compressor form, a signed linear word written to the buffer is reduced to an 8-bit A-law or mu-law code. In expander form, the low byte of the buffer is read as a code and turned into a signed linear sample.

Software picks the law through a two-bit law field and then writes the word. The raw word is visible for one cycle while a busy flag is high. On the next clock the converted result replaces it in the same buffer register. The block can therefore be used as a standalone conversion engine, for example in test, by writing a word, waiting one cycle and reading it back. With companding off, the buffer is a plain register.

Top module: `g711_buf_compander`

## Requirements
- R1: During and immediately after synchronous active-low reset, `rd_data` is zero and `busy` is low.
- R2: A write (`wr_en` high at a rising edge) places `wr_data` unchanged on `rd_data` in the following cycle. In that cycle `busy` is high exactly when the law field sampled with the write selects a law.
- R3: In the cycle after `busy` was high with no new write, `rd_data` holds the converted word and `busy` is low. `busy` never stays high for two cycles without a new write.
- R4: The law field uses these encodings: 2'b10 is mu-law, 2'b11 is A-law, and 2'b00 and 2'b01 mean companding is off. The field is captured with each write, so changing it afterwards does not affect the pending conversion.
- R5: With companding off, a written word stays on `rd_data` unchanged until the next write, and `busy` stays low.
- R6: Compressor codes are standard G.711, with the input taken as a signed two's-complement word. For A-law, the input is a 13-bit sample, the magnitude of a negative value is its one's complement, and the code is {sign, segment[2:0], mantissa[3:0]} XOR 0x55, with the sign bit set for non-negative input. For mu-law, the input is a 14-bit sample, a bias of 33 is added to the magnitude before the segment search, and the code is inverted, so that non-negative input gives bit 7 set.
- R7: In compressor form, bits 31:8 of the converted word are zero.
- R8: Over-range input saturates. A-law gives 0xAA for input above 4095 and 0x2A for input below -4096. Mu-law clamps the magnitude to 8159, so large positive input gives 0x80 and large negative input gives 0x00.
- R9: In expander form, bits 31:8 of the written word are ignored. Bits 7:0 are decoded per G.711, to a 14-bit mu-law sample (range ±8031) or a 13-bit A-law sample (range ±4032), right-justified and sign-extended to 32 bits.
- R10: A write in the busy cycle takes priority. The new word is captured and the earlier pending conversion is dropped.
- R11: Parameter `COMPRESS` set to 1 builds the compressor and set to 0 builds the expander. Both forms share the same port list and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| law_sel | input | 2 | Law field: 00/01 off, 10 mu-law, 11 A-law |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | 32 | Word written to the buffer |
| rd_data | output | 32 | Current buffer contents |
| busy | output | 1 | High during the single conversion cycle |

## Verification
The bench goes after the segment boundaries of both laws. If the threshold ladder or the mantissa shift is off by one, codes near powers of two come out one segment or one step wrong. It drives values just inside and just beyond the clip limits and the most negative word. Getting these wrong shows up as a wrapped code in place of the saturated one, or as a broken mu-law negation. All 256 codes are expanded with random upper bits, so a decoder that reads the upper bits or drops the sign extension gives wrong high bits. Back-to-back writes and a law change during the busy cycle expose a design that converts twice or converts with the wrong law.

// File: rtl/g711_pkg.sv
// Package: shared law encoding and G.711 constants for the buffer compander.
// Assumes a two-bit law field where the upper bit alone means "active".
package g711_pkg;

    typedef enum logic [1:0] {
        LAW_OFF  = 2'b00,
        LAW_RSVD = 2'b01,
        LAW_MU   = 2'b10,
        LAW_A    = 2'b11
    } law_e;

    localparam int A_LIN_MAX   = 4095;  // largest 13-bit A-law magnitude
    localparam int MU_CLIP     = 8159;  // mu-law magnitude clamp
    localparam int MU_BIAS     = 33;    // mu-law bias on 14-bit scale
    localparam int A_SEG_BASE  = 32;    // first A-law segment end + 1
    localparam int MU_SEG_BASE = 64;    // first mu-law segment end + 1
    localparam int CODE_W      = 8;

    // True when the field selects one of the two laws.
    function automatic logic law_active(law_e l);
        return (l == LAW_MU) || (l == LAW_A);
    endfunction

endpackage

// File: rtl/g711_compress.sv
// Module: linear-to-G.711 encoder, purely combinational.
// Assumes lin_in is a signed two's-complement sample right-justified in WORD_W bits.
// A-law treats it as 13-bit, mu-law as 14-bit; out-of-range magnitudes saturate.
module g711_compress
    import g711_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] lin_in,
    input  logic              is_alaw,
    output logic [CODE_W-1:0] code_out
);

    localparam int SEGS = 8;

    logic              neg;
    logic [WORD_W-1:0] mag;
    logic [WORD_W-1:0] thr_base;
    logic [CODE_W-1:0] xmask;
    logic [3:0]        nseg;
    logic [3:0]        sh;
    logic [3:0]        mant;

    // Sign handling, clamp and bias for the selected law.
    always_comb begin
        neg = lin_in[WORD_W-1];
        if (is_alaw) begin
            xmask    = neg ? 8'h55 : 8'hD5;
            mag      = neg ? ~lin_in : lin_in;
            thr_base = WORD_W'(A_SEG_BASE);
        end else begin
            xmask    = neg ? 8'h7F : 8'hFF;
            mag      = neg ? (~lin_in + WORD_W'(1)) : lin_in;
            if (mag > WORD_W'(MU_CLIP))
                mag = WORD_W'(MU_CLIP);
            mag      = mag + WORD_W'(MU_BIAS);
            thr_base = WORD_W'(MU_SEG_BASE);
        end
    end

    // Segment search: count how many segment end points the magnitude exceeds.
    always_comb begin
        nseg = 4'd0;
        for (int s = 0; s < SEGS; s++) begin
            if (mag > ((thr_base << s) - WORD_W'(1)))
                nseg = nseg + 4'd1;
        end
    end

    // Mantissa extraction and final code assembly with saturation.
    always_comb begin
        if (is_alaw)
            sh = (nseg < 4'd2) ? 4'd1 : nseg;
        else
            sh = nseg + 4'd1;
        mant = 4'(mag >> sh);
        if (nseg[3])
            code_out = 8'h7F ^ xmask;
        else
            code_out = {1'b0, nseg[2:0], mant} ^ xmask;
    end

    // Saturated positive A-law input must give the top positive code.
    always_comb begin
        if (is_alaw && !lin_in[WORD_W-1] && (lin_in > WORD_W'(A_LIN_MAX)))
            AST_A_POS_SAT: assert (code_out == 8'hAA); // R8
    end

endmodule

// File: rtl/g711_expand.sv
// Module: G.711-to-linear decoder, purely combinational.
// Assumes code_in is an 8-bit A-law or mu-law code; output is right-justified
// and sign-extended to WORD_W bits (13-bit A-law, 14-bit mu-law scale).
module g711_expand
    import g711_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [CODE_W-1:0] code_in,
    input  logic              is_alaw,
    output logic [WORD_W-1:0] lin_out
);

    logic [CODE_W-1:0] cw;
    logic [2:0]        seg;
    logic [3:0]        m;
    logic [WORD_W-1:0] step;
    logic [WORD_W-1:0] t;
    logic              negative;

    // Undo the line coding and split into sign, segment and mantissa.
    always_comb begin
        cw       = is_alaw ? (code_in ^ 8'h55) : ~code_in;
        seg      = cw[6:4];
        m        = cw[3:0];
        negative = is_alaw ? ~cw[7] : cw[7];
        step     = WORD_W'({m, 1'b0}) + WORD_W'(MU_BIAS);
    end

    // Rebuild the magnitude for the selected law.
    always_comb begin
        if (is_alaw) begin
            if (seg == 3'd0)
                t = WORD_W'({m, 1'b1});
            else
                t = step << (seg - 3'd1);
        end else begin
            t = (step << seg) - WORD_W'(MU_BIAS);
        end
    end

    // Apply the sign in two's complement.
    always_comb begin
        lin_out = negative ? (~t + WORD_W'(1)) : t;
    end

endmodule

// File: rtl/g711_inplace_ctrl.sv
// Module: buffer register and one-cycle in-place conversion sequencer.
// Assumes conv_in is a combinational function of buf_out and law_out.
// A write captures the raw word and the law; the following edge replaces
// the word with conv_in when a law was active. Writes win over conversion.
module g711_inplace_ctrl
    import g711_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  law_e              law_in,
    input  logic [WORD_W-1:0] conv_in,
    output logic [WORD_W-1:0] buf_out,
    output law_e              law_out,
    output logic              busy_out
);

    // Buffer, captured law and busy flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_out  <= '0;
            law_out  <= LAW_OFF;
            busy_out <= 1'b0;
        end else if (wr_en) begin
            buf_out  <= wr_data;
            law_out  <= law_in;
            busy_out <= law_active(law_in);
        end else if (busy_out) begin
            buf_out  <= conv_in;
            busy_out <= 1'b0;
        end
    end

    AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_out) |-> $past(wr_en)); // R2

    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_out && !wr_en |=> !busy_out); // R3

endmodule

// File: rtl/g711_buf_compander.sv
// Module: top of the in-place G.711 buffer compander.
// COMPRESS=1 builds the linear-to-code direction, COMPRESS=0 the code-to-linear one.
// Assumes the law field is set before the data word is written.
module g711_buf_compander
    import g711_pkg::*;
#(
    parameter bit COMPRESS = 1'b1,
    parameter int WORD_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        law_sel,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              busy
);

    localparam int SIGN_LO = 13;  // lowest bit that must equal the sign after expansion

    law_e              law_q;
    logic [WORD_W-1:0] buf_q;
    logic [WORD_W-1:0] conv;
    logic              is_alaw;

    assign is_alaw = (law_q == LAW_A);

    g711_inplace_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .law_in   (law_e'(law_sel)),
        .conv_in  (conv),
        .buf_out  (buf_q),
        .law_out  (law_q),
        .busy_out (busy)
    );

    // Direction chosen at build time.
    generate
        if (COMPRESS) begin : g_cmp
            logic [CODE_W-1:0] code;
            g711_compress #(.WORD_W(WORD_W)) u_cmp (
                .lin_in   (buf_q),
                .is_alaw  (is_alaw),
                .code_out (code)
            );
            assign conv = {{(WORD_W-CODE_W){1'b0}}, code};

            AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
                busy && !wr_en |=> rd_data[WORD_W-1:CODE_W] == '0); // R7
        end else begin : g_exp
            g711_expand #(.WORD_W(WORD_W)) u_exp (
                .code_in (buf_q[CODE_W-1:0]),
                .is_alaw (is_alaw),
                .lin_out (conv)
            );

            AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
                busy && !wr_en |=> ((&rd_data[WORD_W-1:SIGN_LO]) || !(|rd_data[WORD_W-1:SIGN_LO]))); // R9
        end
    endgenerate

    assign rd_data = buf_q;

    AST_WR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == $past(wr_data)); // R2

    AST_BUSY_ON_LAW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> busy == $past(law_sel[1])); // R4

    AST_OFF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !wr_en |=> $stable(rd_data)); // R5

endmodule

// File: tb/g711_buf_compander_tb.sv
module g711_buf_compander_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  law_sel;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_c, rd_x;
    logic        busy_c, busy_x;

    int    total = 0;
    int    bad   = 0;
    string cur_req = "R1";

    // reference model state
    logic [31:0] m_bc, m_bx;
    logic        m_busy;
    logic [1:0]  m_law;

    always #(CLK_PERIOD/2) clk = ~clk;

    g711_buf_compander #(.COMPRESS(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .law_sel(law_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_c), .busy(busy_c));

    g711_buf_compander #(.COMPRESS(1'b0)) u_dut_x (
        .clk(clk), .rst_n(rst_n), .law_sel(law_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_x), .busy(busy_x));

    function automatic logic [7:0] ref_mu_enc(longint x);
        longint m; logic [7:0] mask; int seg;
        if (x < 0) begin m = -x; mask = 8'h7F; end else begin m = x; mask = 8'hFF; end
        if (m > 8159) m = 8159;
        m = m + 33;
        seg = 0;
        while (seg < 8 && m > ((64 << seg) - 1)) seg++;
        if (seg >= 8) return 8'h7F ^ mask;
        return 8'(((seg << 4) | ((m >> (seg + 1)) & 15))) ^ mask;
    endfunction

    function automatic logic [7:0] ref_a_enc(longint x);
        longint m; logic [7:0] mask; int seg;
        if (x >= 0) begin m = x; mask = 8'hD5; end else begin m = -x - 1; mask = 8'h55; end
        seg = 0;
        while (seg < 8 && m > ((32 << seg) - 1)) seg++;
        if (seg >= 8) return 8'h7F ^ mask;
        if (seg < 2) return 8'(((seg << 4) | ((m >> 1) & 15))) ^ mask;
        return 8'(((seg << 4) | ((m >> seg) & 15))) ^ mask;
    endfunction

    function automatic int ref_mu_dec(logic [7:0] c);
        int u, seg, t;
        u = int'(~c);
        seg = (u >> 4) & 7;
        t = (((u & 15) << 1) + 33) << seg;
        return ((u & 128) != 0) ? (33 - t) : (t - 33);
    endfunction

    function automatic int ref_a_dec(logic [7:0] c);
        int a, seg, t;
        a = int'(c ^ 8'h55);
        seg = (a >> 4) & 7;
        if (seg == 0) t = ((a & 15) << 1) + 1;
        else t = (((a & 15) << 1) + 33) << (seg - 1);
        return ((a & 128) != 0) ? t : -t;
    endfunction

    // reference model: one update per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_bc = '0; m_bx = '0; m_busy = 1'b0; m_law = 2'b00;
        end else if (wr_en) begin
            m_bc = wr_data; m_bx = wr_data; m_law = law_sel; m_busy = law_sel[1];
        end else if (m_busy) begin
            if (m_law == 2'b11) begin
                m_bc = {24'b0, ref_a_enc(longint'($signed(m_bc)))};
                m_bx = 32'(ref_a_dec(m_bx[7:0]));
            end else begin
                m_bc = {24'b0, ref_mu_enc(longint'($signed(m_bc)))};
                m_bx = 32'(ref_mu_dec(m_bx[7:0]));
            end
            m_busy = 1'b0;
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    // compare all outputs at the falling edge, then drive the next inputs
    task automatic cyc(input logic we, input logic [31:0] d, input logic [1:0] l);
        @(negedge clk);
        check({31'b0, busy_c}, {31'b0, m_busy}, "busy cmp");
        check(rd_c, m_bc, "rd_data cmp");
        check({31'b0, busy_x}, {31'b0, m_busy}, "busy exp");
        check(rd_x, m_bx, "rd_data exp");
        wr_en = we; wr_data = d; law_sel = l;
    endtask

    task automatic conv(input logic [31:0] d, input logic [1:0] l);
        cyc(1'b1, d, l);
        cyc(1'b0, 32'h0, l);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R3 actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = 32'hDEAD_BEEF; law_sel = 2'b11;
        cur_req = "R1";
        repeat (3) cyc(1'b1, 32'h1234_5678, 2'b11);
        rst_n = 1'b1;
        cyc(1'b0, 32'h0, 2'b00);

        cur_req = "R5";
        for (int i = 0; i < 20; i++) begin
            cyc(1'b1, $urandom, 2'b00);
            repeat (3) cyc(1'b0, 32'h0, 2'b00);
        end

        cur_req = "R4";
        for (int i = 0; i < 10; i++) conv($urandom, 2'b01);
        cyc(1'b1, 32'd1000, 2'b10);   // law switched during busy cycle
        cyc(1'b0, 32'h0, 2'b11);
        cyc(1'b0, 32'h0, 2'b00);
        cyc(1'b1, 32'hFFFF_FC18, 2'b11);
        cyc(1'b0, 32'h0, 2'b10);
        cyc(1'b0, 32'h0, 2'b00);

        cur_req = "R6 R7 R11 R2 R3";
        for (int v = -9000; v <= 9000; v += 7) conv(32'(v), 2'b10);
        for (int v = -4600; v <= 4600; v += 3) conv(32'(v), 2'b11);
        for (int k = 0; k < 13; k++) begin
            conv(32'(1 << k), 2'b10); conv(32'((1 << k) - 1), 2'b10);
            conv(32'(-(1 << k)), 2'b10); conv(32'(1 << k), 2'b11);
            conv(32'((1 << k) - 1), 2'b11); conv(32'(-(1 << k)), 2'b11);
        end

        cur_req = "R9 R11";
        for (int c = 0; c < 256; c++) begin
            conv({$urandom_range(0, 32'hFF_FFFF) , 8'(c)} & 32'hFFFF_FFFF, 2'b10);
            conv({8'(c) ^ 8'h00, 8'(c)} | 32'hFF00_0000, 2'b11);
            conv({24'h0, 8'(c)}, 2'b11);
        end

        cur_req = "R8";
        conv(32'd4095, 2'b11);  conv(32'd4096, 2'b11);
        conv(32'hFFFF_F000, 2'b11); conv(32'hFFFF_EFFF, 2'b11);
        conv(32'd8159, 2'b10);  conv(32'd8160, 2'b10);
        conv(32'hFFFF_E021, 2'b10); conv(32'hFFFF_E020, 2'b10);
        conv(32'd100000, 2'b10); conv(32'd100000, 2'b11);
        conv(32'h7FFF_FFFF, 2'b10); conv(32'h7FFF_FFFF, 2'b11);
        conv(32'h8000_0000, 2'b10); conv(32'h8000_0000, 2'b11);

        cur_req = "R10";
        for (int i = 0; i < 16; i++)
            cyc(1'b1, $urandom_range(0, 20000) - 10000, (i % 3 == 0) ? 2'b00 : {1'b1, 1'(i)});
        repeat (3) cyc(1'b0, 32'h0, 2'b00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule